// File: doc/BRIEF.md
# Stallable Tagged Pipeline Controller

This block moves a data word and a side-band tag through a fixed chain of register stages. Each stage applies a small transform to the data. Both edges of the block use a ready/valid handshake. A transfer happens on either side only in a cycle where valid and ready are both high.

A vector of per-stage occupancy bits records which slots hold live work. The busy flag is the OR of that vector. When the consumer stops taking results, the oldest result waits in the last slot. Younger results keep moving forward into empty slots, and the producer is turned away only once every slot is occupied. The consumer sees only the handshake, so changing the number of stages needs no change outside the block.

Top module: `tagged_pipe_ctrl`

## Requirements
- R1: The active-low reset is asynchronous. While `rst_n` is low, every slot is emptied at once, without waiting for a clock edge: `valid_out` and `busy` read 0 and `ready_out` reads 1.
- R2: An input is taken only at a rising clock edge where `valid_in` and `ready_out` are both high. An input presented while `ready_out` is low is dropped and never appears at the output.
- R3: Every accepted input produces exactly one result cycle on `valid_out`. Results leave in acceptance order, and each carries on `tag_out` the tag that was captured with it.
- R4: With the default indexed-add transform, stage k (k = 1..DEPTH) adds k to the data. The result is therefore `data_out` = `data_in` + DEPTH*(DEPTH+1)/2, modulo 2^DATA_W.
- R5: `valid_out` is never high in a cycle where `ready_in` is low.
- R6: While `ready_in` is low and the last slot holds a result, that slot stays occupied, and `data_out` and `tag_out` hold their values.
- R7: `ready_out` is high whenever `ready_in` is high or at least one slot is empty. With `ready_in` held low, the block accepts exactly DEPTH inputs and then drives `ready_out` low.
- R8: `busy` is high exactly while any slot is occupied. It falls only after a result has left, and it reads 0 once all accepted work has been delivered.
- R9: When `ready_in` stays high, a result appears DEPTH cycles after its input is accepted, and back-to-back inputs are accepted and delivered one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Producer offers an input this cycle |
| ready_out | output | 1 | Block can take an input this cycle |
| tag_in | input | TAG_W | Side-band tag that travels with the input |
| data_in | input | DATA_W | Input data word |
| valid_out | output | 1 | A result is delivered this cycle |
| ready_in | input | 1 | Consumer can take a result this cycle |
| busy | output | 1 | At least one slot is occupied |
| tag_out | output | TAG_W | Tag of the result in the last slot |
| data_out | output | DATA_W | Transformed data of the result in the last slot |

## Verification
A wrong occupancy bit shows up at the ports within DEPTH cycles: a dropped bit loses a tag from the ordered stream, and a duplicated bit repeats a tag. An advance decision that ignores a stall shows up in the first stalled cycle, as a change of `tag_out` or `data_out` or as `valid_out` without `ready_in`. A fullness decision that is wrong shows up as `ready_out` staying high after DEPTH stalled accepts, or as an ignored input reappearing in the output order. A transform fault changes `data_out` on the first result that reaches the port.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    // Per-stage data transform selection.
    typedef enum logic [0:0] {
        XF_PASS      = 1'b0,   // stage forwards data unchanged
        XF_ADD_INDEX = 1'b1    // stage k adds k to the data
    } xform_e;
endpackage

// File: rtl/tpc_adv_chain.sv
// Decides for each slot whether it may load new contents this cycle.
// A slot advances when there is a gap at or below it in the chain,
// or when the consumer is ready to drain the last slot.
module tpc_adv_chain #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] stage_vld,
    input  logic             ready_in,
    output logic [DEPTH-1:0] adv
);
    logic gap;

    always_comb begin
        gap = ready_in;
        adv = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            gap    = gap | ~stage_vld[i];
            adv[i] = gap;
        end
    end
endmodule

// File: rtl/tpc_stage.sv
// One slot of the pipeline: occupancy bit, tag and transformed data.
module tpc_stage
    import tpc_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     TAG_W  = 8,
    parameter int     IDX    = 0,
    parameter xform_e XFORM  = XF_ADD_INDEX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              vld_in,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              vld_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] data_q
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t             slot_d;
    slot_t             slot_q;
    logic [DATA_W-1:0] xf_data;

    generate
        if (XFORM == XF_ADD_INDEX) begin : g_add
            localparam logic [DATA_W-1:0] INC = DATA_W'(IDX + 1);
            assign xf_data = data_in + INC;
        end else begin : g_pass
            assign xf_data = data_in;
        end
    endgenerate

    always_comb begin
        slot_d = slot_q;
        if (adv) begin
            slot_d.vld = vld_in;
            if (vld_in) begin
                slot_d.tag  = tag_in;
                slot_d.data = xf_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign vld_q  = slot_q.vld;
    assign tag_q  = slot_q.tag;
    assign data_q = slot_q.data;
endmodule

// File: rtl/tagged_pipe_ctrl.sv
module tagged_pipe_ctrl
    import tpc_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     TAG_W  = 8,
    parameter int     DEPTH  = 4,
    parameter xform_e XFORM  = XF_ADD_INDEX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    output logic              ready_out,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid_out,
    input  logic              ready_in,
    output logic              busy,
    output logic [TAG_W-1:0]  tag_out,
    output logic [DATA_W-1:0] data_out
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0]  stage_vld;
    logic [DEPTH-1:0]  adv;
    logic [TAG_W-1:0]  stage_tag  [DEPTH];
    logic [DATA_W-1:0] stage_data [DEPTH];

    tpc_adv_chain #(.DEPTH(DEPTH)) u_adv (
        .stage_vld (stage_vld),
        .ready_in  (ready_in),
        .adv       (adv)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            logic              src_vld;
            logic [TAG_W-1:0]  src_tag;
            logic [DATA_W-1:0] src_data;
            if (g == 0) begin : g_head
                assign src_vld  = valid_in;
                assign src_tag  = tag_in;
                assign src_data = data_in;
            end else begin : g_body
                assign src_vld  = stage_vld[g-1];
                assign src_tag  = stage_tag[g-1];
                assign src_data = stage_data[g-1];
            end
            tpc_stage #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W),
                .IDX    (g),
                .XFORM  (XFORM)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv[g]),
                .vld_in  (src_vld),
                .tag_in  (src_tag),
                .data_in (src_data),
                .vld_q   (stage_vld[g]),
                .tag_q   (stage_tag[g]),
                .data_q  (stage_data[g])
            );
        end
    endgenerate

    assign ready_out = adv[0];
    assign valid_out = stage_vld[LAST] & ready_in;
    assign busy      = |stage_vld;
    assign tag_out   = stage_tag[LAST];
    assign data_out  = stage_data[LAST];
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 8,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic              ready_out,
    input logic              valid_out,
    input logic              ready_in,
    input logic              busy,
    input logic [TAG_W-1:0]  tag_out,
    input logic [DATA_W-1:0] data_out,
    input logic [DEPTH-1:0]  stage_vld
);
    AST_EMIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> ready_in); // R5

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_vld[DEPTH-1] && !ready_in) |=>
        (stage_vld[DEPTH-1] && $stable(data_out) && $stable(tag_out))); // R6

    AST_READY_WHEN_DOWN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_in |-> ready_out); // R7

    AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (&stage_vld && !ready_in) |-> !ready_out); // R7

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ready_out) |=> busy); // R2

    AST_BUSY_FALLS_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(valid_out)); // R8

    AST_NO_EMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !valid_out); // R3
endmodule

bind tagged_pipe_ctrl tpc_checker #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .ready_out (ready_out),
    .valid_out (valid_out),
    .ready_in  (ready_in),
    .busy      (busy),
    .tag_out   (tag_out),
    .data_out  (data_out),
    .stage_vld (stage_vld)
);

// File: tb/tagged_pipe_ctrl_bench.sv
`timescale 1ns/1ps
module tagged_pipe_ctrl_bench;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 8;
    localparam int DEPTH  = 4;
    localparam logic [DATA_W-1:0] SUMINC = DATA_W'(DEPTH * (DEPTH + 1) / 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_in = 1'b0;
    logic              ready_out;
    logic [TAG_W-1:0]  tag_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic              valid_out;
    logic              ready_in = 1'b0;
    logic              busy;
    logic [TAG_W-1:0]  tag_out;
    logic [DATA_W-1:0] data_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit chk_lat = 1'b0;
    logic [TAG_W-1:0]  next_tag = '0;
    logic [TAG_W-1:0]  exp_tag[$];
    logic [DATA_W-1:0] exp_dat[$];
    int                exp_cyc[$];

    always #10 clk = ~clk;

    tagged_pipe_ctrl #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .DEPTH  (DEPTH)
    ) u_tagged_pipe_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .ready_out (ready_out),
        .tag_in    (tag_in),
        .data_in   (data_in),
        .valid_out (valid_out),
        .ready_in  (ready_in),
        .busy      (busy),
        .tag_out   (tag_out),
        .data_out  (data_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One clock cycle: drive at the falling edge, evaluate 1 ns later the
    // handshakes that the next rising edge will complete.
    task automatic cycle(input bit vin, input bit rin);
        @(negedge clk);
        valid_in = vin;
        ready_in = rin;
        tag_in   = next_tag;
        data_in  = DATA_W'($urandom);
        #1;
        if (valid_out) begin
            check(ready_in, "R5", "valid_out without ready_in", 0, 1);
            if (exp_tag.size() == 0) begin
                check(1'b0, "R3", "result with nothing outstanding", 1, 0);
            end else begin
                logic [TAG_W-1:0]  et;
                logic [DATA_W-1:0] ed;
                int                ec;
                et = exp_tag.pop_front();
                ed = exp_dat.pop_front();
                ec = exp_cyc.pop_front();
                check(tag_out == et, "R3", "tag order", tag_out, et);
                check(data_out == ed, "R4", "transformed data", data_out, ed);
                if (chk_lat)
                    check(cyc - ec == DEPTH, "R9", "latency", cyc - ec, DEPTH);
            end
        end
        if (valid_in && ready_out) begin
            exp_tag.push_back(tag_in);
            exp_dat.push_back(data_in + SUMINC);
            exp_cyc.push_back(cyc);
            next_tag = next_tag + 1'b1;
        end
        cyc++;
    endtask

    task automatic drain();
        for (int i = 0; i < 10 * DEPTH && exp_tag.size() != 0; i++)
            cycle(1'b0, 1'b1);
        check(exp_tag.size() == 0, "R3", "outstanding after drain", exp_tag.size(), 0);
        cycle(1'b0, 1'b1);
        check(busy == 1'b0, "R8", "busy after drain", busy, 0);
        check(valid_out == 1'b0, "R3", "valid_out after drain", valid_out, 0);
    endtask

    task automatic t_reset();
        #1;
        check(valid_out == 1'b0, "R1", "valid_out in reset", valid_out, 0);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(ready_out == 1'b1, "R1", "ready_out in reset", ready_out, 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        chk_lat = 1'b1;
        cycle(1'b1, 1'b1);
        for (int i = 0; i < DEPTH - 1; i++) cycle(1'b0, 1'b1);
        check(busy == 1'b1, "R8", "busy while in flight", busy, 1);
        drain();
        chk_lat = 1'b0;
    endtask

    task automatic t_stream();
        int outs;
        chk_lat = 1'b1;
        outs = 0;
        for (int i = 0; i < 3 * DEPTH; i++) begin
            cycle(1'b1, 1'b1);
            check(ready_out == 1'b1, "R9", "accept every cycle", ready_out, 1);
            if (valid_out) outs++;
        end
        check(outs == 2 * DEPTH, "R9", "results per cycle", outs, 2 * DEPTH);
        drain();
        chk_lat = 1'b0;
    endtask

    task automatic t_fill_stall();
        logic [TAG_W-1:0]  held_tag;
        logic [DATA_W-1:0] held_dat;
        for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b0);
        check(exp_tag.size() == DEPTH, "R7", "accepts while stalled",
              exp_tag.size(), DEPTH);
        check(ready_out == 1'b0, "R7", "ready_out when full", ready_out, 0);
        check(busy == 1'b1, "R8", "busy when full", busy, 1);
        held_tag = tag_out;
        held_dat = data_out;
        check(held_tag == exp_tag[0], "R6", "oldest tag waiting", held_tag, exp_tag[0]);
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0);
        check(tag_out == held_tag, "R6", "tag held on stall", tag_out, held_tag);
        check(data_out == held_dat, "R6", "data held on stall", data_out, held_dat);
        check(exp_tag.size() == DEPTH, "R2", "ignored inputs not taken",
              exp_tag.size(), DEPTH);
        // Releasing the consumer must reopen the producer side in the same cycle.
        cycle(1'b0, 1'b1);
        check(ready_out == 1'b1, "R7", "ready_out follows ready_in", ready_out, 1);
        drain();
    endtask

    task automatic t_partial_stall();
        // Two items, then stall: slots behind the waiting result stay open.
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b0);
        for (int i = 0; i < DEPTH; i++) cycle(1'b0, 1'b0);
        check(ready_out == 1'b1, "R7", "ready_out with empty slot", ready_out, 1);
        cycle(1'b1, 1'b0);
        check(exp_tag.size() == 3, "R2", "accepted while slot empty", exp_tag.size(), 3);
        drain();
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++)
            cycle(($urandom % 10) < 6, ($urandom % 2) == 1);
        drain();
    endtask

    task automatic t_async_reset();
        for (int i = 0; i < 2; i++) cycle(1'b1, 1'b0);
        @(negedge clk);
        valid_in = 1'b0;
        #3;
        rst_n = 1'b0;
        #1;
        check(busy == 1'b0, "R1", "busy cleared without edge", busy, 0);
        check(valid_out == 1'b0, "R1", "valid_out cleared", valid_out, 0);
        check(ready_out == 1'b1, "R1", "ready_out after reset", ready_out, 1);
        exp_tag.delete();
        exp_dat.delete();
        exp_cyc.delete();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH + 1; i++) cycle(1'b0, 1'b1);
        check(exp_tag.size() == 0, "R1", "no stale results", exp_tag.size(), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_stream();
        t_fill_stall();
        t_partial_stall();
        t_random();
        t_async_reset();
        t_single();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule